// File: doc/BRIEF.md
# Sector Erase Accept Window Timer

This block sits on the device side of an erasable memory. It follows the queueing phase of a sector-erase operation, after the bus logic has already decoded each command into a class and a sector index. The first sector-erase command opens an accept window. Each further sector-erase command that arrives while the window is open adds its sector to a selection bitmap and starts the whole window again.

The window closes in one of two ways: it runs its full count, or an erase-suspend command arrives first. When it closes, the block gives a one-cycle start pulse to the erase engine and raises its window-closed status bit, which is status bit 3. While the erase runs, the block ignores every command except erase suspend. An erase-suspend command in that phase produces a one-cycle request pulse. A chip-erase command skips the window and starts at once with every sector selected. The erase engine signals completion on `erase_done`, which clears everything and returns the block to idle.

The window length `WINDOW_CYCLES` is the number of clock cycles in 50 µs at the clock rate. The default is 12500, which is 50 µs at 250 MHz.

Top module: `erase_window_timer`

## Requirements
- R1: After reset, `status_timer`, `sector_map`, `erase_start`, `erase_active` and `suspend_req` are all 0.
- R2: In idle, a command with code 1 (sector erase) and `cmd_sector` below NUM_SECTORS sets bit `cmd_sector` of `sector_map` on the next cycle and opens the window, with `status_timer` still 0.
- R3: If no further sector erase is accepted, `erase_start` pulses for exactly one cycle WINDOW_CYCLES cycles after the last accepted sector erase. In that same cycle `status_timer` and `erase_active` become 1.
- R4: A sector erase accepted inside the window ORs its bit into `sector_map` and restarts the full WINDOW_CYCLES count.
- R5: A command with code 3 (erase suspend) inside the window closes the window. `erase_start` then pulses on the next cycle.
- R6: In idle, a command with code 2 (chip erase) raises `erase_start`, `status_timer` and `erase_active` on the next cycle, with every bit of `sector_map` set and no window.
- R7: While `erase_active` is 1, commands with codes 1, 2 and any other non-suspend code leave `sector_map`, `status_timer` and `erase_active` unchanged.
- R8: An erase suspend while `erase_active` is 1 gives a one-cycle `suspend_req` pulse, and the erase continues.
- R9: `erase_done` while erasing returns the block to idle on the next cycle: `sector_map` 0, `status_timer` 0, `erase_active` 0. It takes precedence over a suspend in the same cycle, so no `suspend_req` is raised.
- R10: A sector erase whose index is NUM_SECTORS or above is ignored. The block stays idle and no erase starts.
- R11: Inside the window, chip erase, other commands and `erase_done` are ignored. In idle, `erase_done` and suspend are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_code | input | 3 | Command class: 1 sector erase, 2 chip erase, 3 erase suspend, others ignored |
| cmd_sector | input | $clog2(NUM_SECTORS) | Sector index for a sector erase |
| erase_done | input | 1 | Erase engine finished |
| status_timer | output | 1 | Status bit 3: 0 while idle or the window is open, 1 once the erase has begun |
| sector_map | output | NUM_SECTORS | Sectors selected for erasure |
| erase_start | output | 1 | One-cycle pulse when the erase begins |
| erase_active | output | 1 | Erase in progress |
| suspend_req | output | 1 | One-cycle request to suspend the running erase |

## Verification
Most faults in this block show up at the ports within one window length. A counter that reloads wrongly, or one that fails to reload on an added sector, moves the `erase_start` pulse away from the cycle WINDOW_CYCLES after the last accepted command. A state register stuck in the wrong phase shows in one of two ways: a command that should be ignored changes `sector_map` on the very next cycle, or a suspend produces `erase_start` where it should produce `suspend_req`. The bench runs a behavioural model alongside the design and compares every output on every clock, so a divergence is reported in the cycle it first appears.

// File: rtl/ewt_pkg.sv
package ewt_pkg;

   localparam logic [2:0] CMD_SECTOR_ERASE = 3'd1;
   localparam logic [2:0] CMD_CHIP_ERASE   = 3'd2;
   localparam logic [2:0] CMD_SUSPEND      = 3'd3;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_WINDOW = 2'd1,
      PH_ERASE  = 2'd2
   } phase_t;

   typedef struct packed {
      logic sector;
      logic chip;
      logic suspend;
   } cmd_act_t;

endpackage

// File: rtl/ewt_cmd_filter.sv
module ewt_cmd_filter
   import ewt_pkg::*;
#(
   parameter int NUM_SECTORS = 19,
   localparam int SEC_W = $clog2(NUM_SECTORS)
) (
   input  logic             cmd_valid,
   input  logic [2:0]       cmd_code,
   input  logic [SEC_W-1:0] cmd_sector,
   output cmd_act_t         act
);

   logic in_range;

   generate
      if ((1 << SEC_W) == NUM_SECTORS) begin : g_pow2
         // every encodable index names a real sector
         assign in_range = 1'b1;
      end else begin : g_bounded
         assign in_range = (int'(cmd_sector) < NUM_SECTORS);
      end
   endgenerate

   always_comb begin
      act.sector  = cmd_valid && (cmd_code == CMD_SECTOR_ERASE) && in_range;
      act.chip    = cmd_valid && (cmd_code == CMD_CHIP_ERASE);
      act.suspend = cmd_valid && (cmd_code == CMD_SUSPEND);
   end

endmodule

// File: rtl/ewt_window_counter.sv
module ewt_window_counter #(
   parameter int WINDOW_CYCLES = 12500,
   localparam int CNT_W = $clog2(WINDOW_CYCLES) + 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic run,
   output logic expired
);

   localparam logic [CNT_W-1:0] RELOAD = CNT_W'(WINDOW_CYCLES - 1);

   logic [CNT_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain <= '0;
      end else if (load) begin
         remain <= RELOAD;
      end else if (run && (remain != '0)) begin
         remain <= remain - 1'b1;
      end
   end

   assign expired = run && (remain == '0);

endmodule

// File: rtl/ewt_sector_map.sv
module ewt_sector_map #(
   parameter int NUM_SECTORS = 19,
   localparam int SEC_W = $clog2(NUM_SECTORS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   clr,
   input  logic                   fill,
   input  logic                   set,
   input  logic [SEC_W-1:0]       idx,
   output logic [NUM_SECTORS-1:0] map
);

   for (genvar i = 0; i < NUM_SECTORS; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            map[i] <= 1'b0;
         end else if (clr) begin
            map[i] <= 1'b0;
         end else if (fill) begin
            map[i] <= 1'b1;
         end else if (set && (int'(idx) == i)) begin
            map[i] <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/erase_window_timer.sv
module erase_window_timer
   import ewt_pkg::*;
#(
   parameter int NUM_SECTORS   = 19,
   parameter int WINDOW_CYCLES = 12500,
   localparam int SEC_W = $clog2(NUM_SECTORS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cmd_valid,
   input  logic [2:0]             cmd_code,
   input  logic [SEC_W-1:0]       cmd_sector,
   input  logic                   erase_done,
   output logic                   status_timer,
   output logic [NUM_SECTORS-1:0] sector_map,
   output logic                   erase_start,
   output logic                   erase_active,
   output logic                   suspend_req
);

   generate
      if (NUM_SECTORS < 2) begin : g_bad_sectors
         $error("erase_window_timer: NUM_SECTORS must be at least 2");
      end
      if (WINDOW_CYCLES < 2) begin : g_bad_window
         $error("erase_window_timer: WINDOW_CYCLES must be at least 2");
      end
   endgenerate

   cmd_act_t act;
   phase_t   phase, phase_nxt;
   logic     win_load, win_expired;
   logic     map_set, map_fill, map_clr;
   logic     start_nxt, susp_nxt;

   ewt_cmd_filter #(.NUM_SECTORS(NUM_SECTORS)) u_filter (
      .cmd_valid (cmd_valid),
      .cmd_code  (cmd_code),
      .cmd_sector(cmd_sector),
      .act       (act)
   );

   ewt_window_counter #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_window (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (win_load),
      .run    (phase == PH_WINDOW),
      .expired(win_expired)
   );

   ewt_sector_map #(.NUM_SECTORS(NUM_SECTORS)) u_map (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (map_clr),
      .fill (map_fill),
      .set  (map_set),
      .idx  (cmd_sector),
      .map  (sector_map)
   );

   always_comb begin
      phase_nxt = phase;
      win_load  = 1'b0;
      map_set   = 1'b0;
      map_fill  = 1'b0;
      map_clr   = 1'b0;
      start_nxt = 1'b0;
      susp_nxt  = 1'b0;
      unique case (phase)
         PH_IDLE: begin
            if (act.chip) begin
               map_fill  = 1'b1;
               start_nxt = 1'b1;
               phase_nxt = PH_ERASE;
            end else if (act.sector) begin
               map_set   = 1'b1;
               win_load  = 1'b1;
               phase_nxt = PH_WINDOW;
            end
         end
         PH_WINDOW: begin
            if (act.sector) begin
               map_set  = 1'b1;
               win_load = 1'b1;
            end else if (act.suspend || win_expired) begin
               start_nxt = 1'b1;
               phase_nxt = PH_ERASE;
            end
         end
         PH_ERASE: begin
            if (erase_done) begin
               map_clr   = 1'b1;
               phase_nxt = PH_IDLE;
            end else if (act.suspend) begin
               susp_nxt = 1'b1;
            end
         end
         default: phase_nxt = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase       <= PH_IDLE;
         erase_start <= 1'b0;
         suspend_req <= 1'b0;
      end else begin
         phase       <= phase_nxt;
         erase_start <= start_nxt;
         suspend_req <= susp_nxt;
      end
   end

   assign status_timer = (phase == PH_ERASE);
   assign erase_active = (phase == PH_ERASE);

endmodule

// File: rtl/ewt_checker.sv
module ewt_checker #(
   parameter int NUM_SECTORS = 19
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   erase_done,
   input logic                   status_timer,
   input logic [NUM_SECTORS-1:0] sector_map,
   input logic                   erase_start,
   input logic                   erase_active,
   input logic                   suspend_req
);

   // R3
   start_closes_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      erase_start |-> (status_timer && erase_active));

   // R3
   start_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      erase_start |=> !erase_start);

   // R7
   map_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_timer && $past(status_timer)) |-> $stable(sector_map));

   // R8
   suspend_only_erasing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      suspend_req |-> erase_active);

   // R9
   done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_active && erase_done) |=> (!erase_active && !status_timer && sector_map == '0 && !suspend_req));

   // R2
   window_not_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !status_timer |-> !erase_active);

endmodule

bind erase_window_timer ewt_checker #(.NUM_SECTORS(NUM_SECTORS)) u_ewt_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .erase_done  (erase_done),
   .status_timer(status_timer),
   .sector_map  (sector_map),
   .erase_start (erase_start),
   .erase_active(erase_active),
   .suspend_req (suspend_req)
);

// File: tb/erase_window_timer_bench.sv
module erase_window_timer_bench;

   localparam int N     = 19;
   localparam int W     = 8;
   localparam int SEC_W = $clog2(N);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cmd_valid = 1'b0;
   logic [2:0]       cmd_code = 3'd0;
   logic [SEC_W-1:0] cmd_sector = '0;
   logic             erase_done = 1'b0;
   logic             status_timer, erase_start, erase_active, suspend_req;
   logic [N-1:0]     sector_map;

   int tests = 0;
   int fails = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   erase_window_timer #(.NUM_SECTORS(N), .WINDOW_CYCLES(W)) u_erase_window_timer (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
      .cmd_sector(cmd_sector), .erase_done(erase_done), .status_timer(status_timer),
      .sector_map(sector_map), .erase_start(erase_start), .erase_active(erase_active),
      .suspend_req(suspend_req)
   );

   // behavioural reference: 0 idle, 1 accepting, 2 erasing
   int           m_phase = 0;
   int           m_left  = 0;
   logic [N-1:0] m_map   = '0;
   bit           m_start = 0;
   bit           m_susp  = 0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_phase = 0; m_left = 0; m_map = '0; m_start = 0; m_susp = 0;
      end else begin
         bit is_sec, is_chip, is_susp;
         is_sec  = cmd_valid && cmd_code == 3'd1 && int'(cmd_sector) < N;
         is_chip = cmd_valid && cmd_code == 3'd2;
         is_susp = cmd_valid && cmd_code == 3'd3;
         m_start = 0;
         m_susp  = 0;
         if (m_phase == 0) begin
            if (is_chip) begin
               m_map = '1; m_phase = 2; m_start = 1;
            end else if (is_sec) begin
               m_map[cmd_sector] = 1'b1; m_left = W; m_phase = 1;
            end
         end else if (m_phase == 1) begin
            if (is_sec) begin
               m_map[cmd_sector] = 1'b1; m_left = W;
            end else begin
               m_left = m_left - 1;
               if (is_susp || m_left == 0) begin
                  m_phase = 2; m_start = 1;
               end
            end
         end else begin
            if (erase_done) begin
               m_phase = 0; m_map = '0;
            end else if (is_susp) begin
               m_susp = 1;
            end
         end
      end
   end

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // compare every output against the model on each cycle
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk("R4 map vs model", 64'(sector_map), 64'(m_map));
         chk("R3 status vs model", 64'(status_timer), 64'(m_phase == 2));
         chk("R3 start vs model", 64'(erase_start), 64'(m_start));
         chk("R9 active vs model", 64'(erase_active), 64'(m_phase == 2));
         chk("R8 suspend vs model", 64'(suspend_req), 64'(m_susp));
      end
   end

   task automatic step(input logic [2:0] code, input int sec, input bit v, input bit done);
      cmd_valid  = v;
      cmd_code   = code;
      cmd_sector = SEC_W'(sec);
      erase_done = done;
      @(posedge clk);
      @(negedge clk);
      cmd_valid  = 1'b0;
      cmd_code   = 3'd0;
      erase_done = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(3'd0, 0, 0, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         tests++;
         $display("FAIL watchdog expired");
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 status", 64'(status_timer), 0);
      chk("R1 map", 64'(sector_map), 0);
      chk("R1 start", 64'(erase_start), 0);
      chk("R1 active", 64'(erase_active), 0);
      chk("R1 suspend", 64'(suspend_req), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 / R4 / R3
      step(3'd1, 3, 1, 0);
      chk("R2 map bit", 64'(sector_map), 64'(1 << 3));
      chk("R2 status low", 64'(status_timer), 0);
      idle(5);
      step(3'd1, 7, 1, 0);
      chk("R4 map or", 64'(sector_map), 64'((1 << 3) | (1 << 7)));
      idle(W - 1);
      chk("R4 restarted no start", 64'(erase_start), 0);
      chk("R4 restarted status", 64'(status_timer), 0);
      idle(1);
      chk("R3 start pulse", 64'(erase_start), 1);
      chk("R3 status high", 64'(status_timer), 1);
      idle(1);
      chk("R3 start one cycle", 64'(erase_start), 0);

      // R7 / R8 / R9
      step(3'd1, 1, 1, 0);
      step(3'd2, 0, 1, 0);
      step(3'd5, 0, 1, 0);
      chk("R7 map kept", 64'(sector_map), 64'((1 << 3) | (1 << 7)));
      chk("R7 still active", 64'(erase_active), 1);
      step(3'd3, 0, 1, 0);
      chk("R8 suspend pulse", 64'(suspend_req), 1);
      chk("R8 active kept", 64'(erase_active), 1);
      idle(1);
      chk("R8 pulse ends", 64'(suspend_req), 0);
      step(3'd3, 0, 1, 1);
      chk("R9 map cleared", 64'(sector_map), 0);
      chk("R9 status low", 64'(status_timer), 0);
      chk("R9 done beats suspend", 64'(suspend_req), 0);

      // R10
      step(3'd1, N, 1, 0);
      idle(W + 2);
      chk("R10 map empty", 64'(sector_map), 0);
      chk("R10 not active", 64'(erase_active), 0);

      // R11 / R5
      step(3'd3, 0, 1, 1);
      chk("R11 idle suspend ignored", 64'(erase_active), 0);
      step(3'd1, 0, 1, 0);
      step(3'd0, 0, 0, 1);
      step(3'd2, 0, 1, 0);
      step(3'd6, 0, 1, 0);
      chk("R11 window map", 64'(sector_map), 1);
      chk("R11 window open", 64'(status_timer), 0);
      step(3'd3, 0, 1, 0);
      chk("R5 early start", 64'(erase_start), 1);
      chk("R5 map", 64'(sector_map), 1);
      step(3'd0, 0, 0, 1);

      // R6
      step(3'd2, 0, 1, 0);
      chk("R6 start", 64'(erase_start), 1);
      chk("R6 map full", 64'(sector_map), 64'({N{1'b1}}));
      chk("R6 status", 64'(status_timer), 1);
      step(3'd0, 0, 0, 1);
      idle(2);

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule